// File: doc/BRIEF.md
# Clock Configuration Register Bank with Write Lock

This block is the register file that holds the configuration for a set of clock generators and a set of clock channels. Each generator has a control entry and a divider entry. Each channel has a clock-control entry that names a source generator, carries an enable flag and carries a write-lock flag. Software reaches all three kinds of entry indirectly. Every written word carries an entry number in its low byte. The write stores the rest of the word into that entry and also selects that entry for later reads on the matching read bus.

Setting the lock flag in a channel entry freezes that entry. It also freezes the control and divider entries of the generator the channel names. A power reset is the only thing that clears a lock. A software reset returns unlocked entries to their reset values and leaves locked entries as they are. Generator 0 drives the main clock, so it can never be locked, and every reset returns it to its startup values. The read buses are combinational from the stored state.

Top module: `clkcfg_bank`

## Requirements
- R1: After a power reset, every read bus shows entry 0 and every entry holds zero, except generator 0, which holds its startup control value (default 0x05) and its startup divider value (default 0x0001).
- R2: A write (`wr_en`=1) takes `wr_reg` 0 for generator control, 1 for generator divider and 2 for channel control, with the entry number in `wr_data[7:0]`. Generator control is in bits [15:8] and the divider in bits [23:8]. A channel entry has its source generator in [11:8], its enable in bit 14 and its lock in bit 15. From the next cycle, the matching read bus returns the stored fields at the same positions, the entry number in [7:0] and zero in every other bit.
- R3: Each of the three registers keeps its own read selector, and a write to one register leaves the other two read buses unchanged.
- R4: A write whose entry number is at or above the implemented count changes no entry, and that register's read bus then shows all zeros.
- R5: After a channel's lock bit is set, later writes leave that channel's fields unchanged, but they still move the read selector to that channel.
- R6: While any locked channel names generator g (g≠0), writes to the control and divider entries of g are ignored, and they still select g for reading.
- R7: Generator 0 stays writable even when a locked channel names it.
- R8: A software reset (`soft_rst`=1) clears all three read selectors to 0 and returns every unlocked channel and generator entry to its power-reset value. It returns generator 0 to its startup values. It leaves locked channels and locked generators unchanged.
- R9: Only a power reset (`por_n`=0) clears the lock bits, after which former locked entries accept writes again.
- R10: When a software reset and a write arrive in the same cycle, the software reset takes effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power reset, active low, synchronous; clears everything including locks |
| soft_rst | input | 1 | Software reset, active high, synchronous; spares locked entries |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | 2 | Register select: 0 generator control, 1 generator divider, 2 channel control, 3 none |
| wr_data | input | 32 | Write word: entry number in [7:0], payload above it |
| rd_gctrl | output | 32 | Selected generator control entry |
| rd_gdiv | output | 32 | Selected generator divider entry |
| rd_chan | output | 32 | Selected channel control entry |

## Verification
The read buses come straight from the stored entries and selectors. A wrong payload or a wrong selector therefore shows on the port in the first cycle after the write that caused it. A wrong lock state stays hidden until a later write to the affected entry is stored or ignored when it should not be. The bench therefore follows every lock with a write to the channel and to the generator it names, and reads the result back. A lock that does not spread to the generator, a lock placed on generator 0, or a software reset that disturbs a locked entry shows up one cycle after the probing write. A behavioural model is compared with all three read buses on every clock.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
   // entry number lives in the low byte of every written word
   localparam int ID_W         = 8;
   localparam int PAY_LSB      = 8;
   // channel word layout
   localparam int GSEL_FIELD_W = 4;
   localparam int CH_EN_BIT    = 14;
   localparam int CH_LOCK_BIT  = 15;

   typedef enum logic [1:0] {
      REG_GCTRL = 2'd0,
      REG_GDIV  = 2'd1,
      REG_CHAN  = 2'd2,
      REG_NONE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/clkcfg_id_select.sv
module clkcfg_id_select #(
   parameter int ID_W = 8,
   parameter int NUM  = 4
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            soft_rst,
   input  logic            we,
   input  logic [ID_W-1:0] wr_id,
   output logic [ID_W-1:0] sel,
   output logic            sel_valid
);
   always_ff @(posedge clk) begin
      if (!por_n)        sel <= '0;
      else if (soft_rst) sel <= '0;
      else if (we)       sel <= wr_id;
   end

   assign sel_valid = (int'(sel) < NUM);
endmodule

// File: rtl/clkcfg_gen_bank.sv
module clkcfg_gen_bank #(
   parameter int                NUM_GEN   = 6,
   parameter int                CTRL_W    = 8,
   parameter int                DIV_W     = 16,
   parameter int                ID_W      = 8,
   parameter logic [CTRL_W-1:0] GEN0_CTRL = '0,
   parameter logic [DIV_W-1:0]  GEN0_DIV  = '0
) (
   input  logic                            clk,
   input  logic                            por_n,
   input  logic                            soft_rst,
   input  logic [NUM_GEN-1:0]              gen_lock,
   input  logic                            ctrl_we,
   input  logic                            div_we,
   input  logic [ID_W-1:0]                 wr_id,
   input  logic [CTRL_W-1:0]               ctrl_wdata,
   input  logic [DIV_W-1:0]                div_wdata,
   output logic [NUM_GEN-1:0][CTRL_W-1:0]  ctrl_q,
   output logic [NUM_GEN-1:0][DIV_W-1:0]   div_q
);
   for (genvar g = 0; g < NUM_GEN; g++) begin : g_ent
      localparam logic [CTRL_W-1:0] CTRL_RST = (g == 0) ? GEN0_CTRL : '0;
      localparam logic [DIV_W-1:0]  DIV_RST  = (g == 0) ? GEN0_DIV  : '0;

      logic hit;
      assign hit = (wr_id == ID_W'(g));

      always_ff @(posedge clk) begin
         if (!por_n) begin
            ctrl_q[g] <= CTRL_RST;
         end else if (soft_rst) begin
            if (!gen_lock[g]) ctrl_q[g] <= CTRL_RST;
         end else if (ctrl_we && hit && !gen_lock[g]) begin
            ctrl_q[g] <= ctrl_wdata;
         end
      end

      always_ff @(posedge clk) begin
         if (!por_n) begin
            div_q[g] <= DIV_RST;
         end else if (soft_rst) begin
            if (!gen_lock[g]) div_q[g] <= DIV_RST;
         end else if (div_we && hit && !gen_lock[g]) begin
            div_q[g] <= div_wdata;
         end
      end

      // R6
      gen_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
         (gen_lock[g] && !soft_rst) |=> ($stable(ctrl_q[g]) && $stable(div_q[g])));

      if (g == 0) begin : g_main
         // R7
         gen0_open_chk: assert property (@(posedge clk) disable iff (!por_n)
            (ctrl_we && hit && !soft_rst) |=> (ctrl_q[g] == $past(ctrl_wdata)));
      end
   end
endmodule

// File: rtl/clkcfg_chan_bank.sv
module clkcfg_chan_bank #(
   parameter int NUM_CH = 10,
   parameter int GSEL_W = 4,
   parameter int ID_W   = 8
) (
   input  logic                          clk,
   input  logic                          por_n,
   input  logic                          soft_rst,
   input  logic                          we,
   input  logic [ID_W-1:0]               wr_id,
   input  logic [GSEL_W-1:0]             wr_gsel,
   input  logic                          wr_on,
   input  logic                          wr_lock,
   output logic [NUM_CH-1:0][GSEL_W-1:0] gsel_q,
   output logic [NUM_CH-1:0]             on_q,
   output logic [NUM_CH-1:0]             lock_q
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ent
      logic hit;
      assign hit = (wr_id == ID_W'(c));

      always_ff @(posedge clk) begin
         if (!por_n) begin
            gsel_q[c] <= '0;
            on_q[c]   <= 1'b0;
            lock_q[c] <= 1'b0;
         end else if (soft_rst) begin
            if (!lock_q[c]) begin
               gsel_q[c] <= '0;
               on_q[c]   <= 1'b0;
            end
         end else if (we && hit && !lock_q[c]) begin
            gsel_q[c] <= wr_gsel;
            on_q[c]   <= wr_on;
            lock_q[c] <= wr_lock;
         end
      end

      // R5
      chan_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
         lock_q[c] |=> ($stable(gsel_q[c]) && $stable(on_q[c])));
      // R9
      lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
         lock_q[c] |=> lock_q[c]);
   end
endmodule

// File: rtl/clkcfg_lock_map.sv
module clkcfg_lock_map #(
   parameter int NUM_CH     = 10,
   parameter int NUM_GEN    = 6,
   parameter int GSEL_W     = 4,
   parameter bit LOCK_COUNT = 1'b1
) (
   input  logic [NUM_CH-1:0][GSEL_W-1:0] gsel,
   input  logic [NUM_CH-1:0]             lock,
   output logic [NUM_GEN-1:0]            gen_lock
);
   localparam int CNT_W = $clog2(NUM_CH + 1);

   // the main-clock generator is exempt from locking
   assign gen_lock[0] = 1'b0;

   for (genvar g = 1; g < NUM_GEN; g++) begin : g_gen
      if (LOCK_COUNT) begin : g_cnt
         logic [CNT_W-1:0] refs;
         always_comb begin
            refs = '0;
            for (int c = 0; c < NUM_CH; c++) begin
               if (lock[c] && (gsel[c] == GSEL_W'(g))) refs = refs + CNT_W'(1);
            end
         end
         assign gen_lock[g] = (refs != '0);
      end else begin : g_or
         logic [NUM_CH-1:0] hits;
         for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
            assign hits[c] = lock[c] && (gsel[c] == GSEL_W'(g));
         end
         assign gen_lock[g] = |hits;
      end
   end
endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
   import clkcfg_pkg::*;
#(
   parameter int                NUM_GEN    = 6,
   parameter int                NUM_CH     = 10,
   parameter int                CTRL_W     = 8,
   parameter int                DIV_W      = 16,
   parameter int                GSEL_W     = 4,
   parameter int                DATA_W     = 32,
   parameter logic [CTRL_W-1:0] GEN0_CTRL  = 8'h05,
   parameter logic [DIV_W-1:0]  GEN0_DIV   = 16'h0001,
   parameter bit                LOCK_COUNT = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_reg,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_gctrl,
   output logic [DATA_W-1:0] rd_gdiv,
   output logic [DATA_W-1:0] rd_chan
);
   // ---------------- elaboration checks ----------------
   if (NUM_GEN < 2 || NUM_GEN > (1 << GSEL_W) || NUM_GEN > (1 << ID_W)) begin : g_bad_gen
      $error("clkcfg_bank: NUM_GEN out of range");
   end
   if (NUM_CH < 1 || NUM_CH > (1 << ID_W)) begin : g_bad_ch
      $error("clkcfg_bank: NUM_CH out of range");
   end
   if (GSEL_W < 1 || GSEL_W > GSEL_FIELD_W) begin : g_bad_gsel
      $error("clkcfg_bank: GSEL_W exceeds its field");
   end
   if (PAY_LSB + DIV_W > DATA_W || PAY_LSB + CTRL_W > DATA_W || CH_LOCK_BIT >= DATA_W) begin : g_bad_w
      $error("clkcfg_bank: payload does not fit the data word");
   end

   // ---------------- write decode ----------------
   reg_sel_e        rsel;
   logic [ID_W-1:0] wr_id;
   logic            we_gc, we_gd, we_ch;

   assign rsel  = reg_sel_e'(wr_reg);
   assign wr_id = wr_data[ID_W-1:0];
   assign we_gc = wr_en && (rsel == REG_GCTRL);
   assign we_gd = wr_en && (rsel == REG_GDIV);
   assign we_ch = wr_en && (rsel == REG_CHAN);

   logic unused_wr;
   assign unused_wr = ^wr_data;

   // ---------------- read selectors ----------------
   logic [ID_W-1:0] gc_sel, gd_sel, ch_sel;
   logic            gc_ok, gd_ok, ch_ok;

   clkcfg_id_select #(.ID_W(ID_W), .NUM(NUM_GEN)) u_sel_gc (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .we(we_gc),
      .wr_id(wr_id), .sel(gc_sel), .sel_valid(gc_ok));
   clkcfg_id_select #(.ID_W(ID_W), .NUM(NUM_GEN)) u_sel_gd (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .we(we_gd),
      .wr_id(wr_id), .sel(gd_sel), .sel_valid(gd_ok));
   clkcfg_id_select #(.ID_W(ID_W), .NUM(NUM_CH)) u_sel_ch (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .we(we_ch),
      .wr_id(wr_id), .sel(ch_sel), .sel_valid(ch_ok));

   // ---------------- storage ----------------
   logic [NUM_GEN-1:0][CTRL_W-1:0] ctrl_q;
   logic [NUM_GEN-1:0][DIV_W-1:0]  div_q;
   logic [NUM_CH-1:0][GSEL_W-1:0]  gsel_q;
   logic [NUM_CH-1:0]              on_q, lock_q;
   logic [NUM_GEN-1:0]             gen_lock;

   clkcfg_chan_bank #(.NUM_CH(NUM_CH), .GSEL_W(GSEL_W), .ID_W(ID_W)) u_chan (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .we(we_ch), .wr_id(wr_id),
      .wr_gsel(wr_data[PAY_LSB +: GSEL_W]), .wr_on(wr_data[CH_EN_BIT]),
      .wr_lock(wr_data[CH_LOCK_BIT]),
      .gsel_q(gsel_q), .on_q(on_q), .lock_q(lock_q));

   clkcfg_lock_map #(.NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN), .GSEL_W(GSEL_W),
                     .LOCK_COUNT(LOCK_COUNT)) u_lock (
      .gsel(gsel_q), .lock(lock_q), .gen_lock(gen_lock));

   clkcfg_gen_bank #(.NUM_GEN(NUM_GEN), .CTRL_W(CTRL_W), .DIV_W(DIV_W), .ID_W(ID_W),
                     .GEN0_CTRL(GEN0_CTRL), .GEN0_DIV(GEN0_DIV)) u_gen (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .gen_lock(gen_lock),
      .ctrl_we(we_gc), .div_we(we_gd), .wr_id(wr_id),
      .ctrl_wdata(wr_data[PAY_LSB +: CTRL_W]), .div_wdata(wr_data[PAY_LSB +: DIV_W]),
      .ctrl_q(ctrl_q), .div_q(div_q));

   // ---------------- read muxes ----------------
   always_comb begin
      rd_gctrl = '0;
      if (gc_ok) begin
         rd_gctrl[ID_W-1:0] = gc_sel;
         for (int g = 0; g < NUM_GEN; g++) begin
            if (gc_sel == ID_W'(g)) rd_gctrl[PAY_LSB +: CTRL_W] = ctrl_q[g];
         end
      end
   end

   always_comb begin
      rd_gdiv = '0;
      if (gd_ok) begin
         rd_gdiv[ID_W-1:0] = gd_sel;
         for (int g = 0; g < NUM_GEN; g++) begin
            if (gd_sel == ID_W'(g)) rd_gdiv[PAY_LSB +: DIV_W] = div_q[g];
         end
      end
   end

   always_comb begin
      rd_chan = '0;
      if (ch_ok) begin
         rd_chan[ID_W-1:0] = ch_sel;
         for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel == ID_W'(c)) begin
               rd_chan[PAY_LSB +: GSEL_W] = gsel_q[c];
               rd_chan[CH_EN_BIT]         = on_q[c];
               rd_chan[CH_LOCK_BIT]       = lock_q[c];
            end
         end
      end
   end

   // ---------------- assertions ----------------
   // R4
   oor_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      (we_gc && !soft_rst && (int'(wr_id) >= NUM_GEN)) |=> (rd_gctrl == '0));
   // R8
   soft_sel_chk: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |=> ((rd_gctrl[ID_W-1:0] == '0) && (rd_gdiv[ID_W-1:0] == '0)
                    && (rd_chan[ID_W-1:0] == '0)));
endmodule

// File: tb/clkcfg_bank_tb.sv
module clkcfg_bank_tb;
   localparam int          CLK_P = 10;
   localparam int          NG    = 6;
   localparam int          NC    = 10;
   localparam logic [7:0]  G0C   = 8'h05;
   localparam logic [15:0] G0D   = 16'h0001;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_reg = 2'd3;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_gctrl, rd_gdiv, rd_chan;

   int checks = 0;
   int fails  = 0;
   bit live   = 1'b0;
   bit done   = 1'b0;
   string tag = "R1";

   // behavioural reference state
   int mgc[NG], mgd[NG], mgs[NC], men[NC], mlk[NC];
   int sg, sd, sc;

   always #(CLK_P/2) clk = ~clk;

   clkcfg_bank u_dut (
      .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .wr_en(wr_en),
      .wr_reg(wr_reg), .wr_data(wr_data),
      .rd_gctrl(rd_gctrl), .rd_gdiv(rd_gdiv), .rd_chan(rd_chan));

   function automatic bit glk(input int g);
      if (g == 0) return 1'b0;
      for (int c = 0; c < NC; c++) if (mlk[c] != 0 && mgs[c] == g) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [31:0] e_gc();
      if (sg >= NG) return '0;
      return (32'(mgc[sg]) << 8) | 32'(sg);
   endfunction
   function automatic logic [31:0] e_gd();
      if (sd >= NG) return '0;
      return (32'(mgd[sd]) << 8) | 32'(sd);
   endfunction
   function automatic logic [31:0] e_ch();
      if (sc >= NC) return '0;
      return (32'(mlk[sc]) << 15) | (32'(men[sc]) << 14) | (32'(mgs[sc]) << 8) | 32'(sc);
   endfunction

   always @(posedge clk) begin
      live = 1'b1;
      if (!por_n) begin
         for (int g = 0; g < NG; g++) begin mgc[g] = 0; mgd[g] = 0; end
         mgc[0] = int'(G0C); mgd[0] = int'(G0D);
         for (int c = 0; c < NC; c++) begin mgs[c] = 0; men[c] = 0; mlk[c] = 0; end
         sg = 0; sd = 0; sc = 0;
      end else if (soft_rst) begin
         for (int g = 0; g < NG; g++) begin
            if (!glk(g)) begin
               mgc[g] = (g == 0) ? int'(G0C) : 0;
               mgd[g] = (g == 0) ? int'(G0D) : 0;
            end
         end
         for (int c = 0; c < NC; c++) if (mlk[c] == 0) begin mgs[c] = 0; men[c] = 0; end
         sg = 0; sd = 0; sc = 0;
      end else if (wr_en) begin
         int id;
         id = int'(wr_data[7:0]);
         case (wr_reg)
            2'd0: begin sg = id; if (id < NG && !glk(id)) mgc[id] = int'(wr_data[15:8]); end
            2'd1: begin sd = id; if (id < NG && !glk(id)) mgd[id] = int'(wr_data[23:8]); end
            2'd2: begin
               sc = id;
               if (id < NC && mlk[id] == 0) begin
                  mgs[id] = int'(wr_data[11:8]);
                  men[id] = int'(wr_data[14]);
                  mlk[id] = int'(wr_data[15]);
               end
            end
            default: ;
         endcase
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // model comparison on every clock, away from the active edge
   always @(negedge clk) begin
      if (live && !done) begin
         chk({tag, " model gctrl"}, rd_gctrl, e_gc());
         chk({tag, " model gdiv"},  rd_gdiv,  e_gd());
         chk({tag, " model chan"},  rd_chan,  e_ch());
      end
   end

   task automatic wr(input logic [1:0] r, input logic [31:0] d);
      wr_en = 1'b1; wr_reg = r; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_reg = 2'd3;
   endtask

   initial begin
      #(CLK_P * 20000);
      checks++; fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      tag = "R1";
      chk("R1 gctrl", rd_gctrl, 32'h0000_0500);
      chk("R1 gdiv",  rd_gdiv,  32'h0000_0100);
      chk("R1 chan",  rd_chan,  32'h0000_0000);

      tag = "R2";
      wr(2'd0, 32'h0000_A503); chk("R2 gctrl", rd_gctrl, 32'h0000_A503);
      wr(2'd1, 32'h0012_3402); chk("R2 gdiv",  rd_gdiv,  32'h0012_3402);
      wr(2'd2, 32'h0000_4204); chk("R2 chan",  rd_chan,  32'h0000_4204);

      tag = "R3";
      wr(2'd0, 32'h0000_1101); chk("R3 gctrl", rd_gctrl, 32'h0000_1101);
      chk("R3 gdiv kept", rd_gdiv, 32'h0012_3402);
      chk("R3 chan kept", rd_chan, 32'h0000_4204);
      wr(2'd0, 32'h0000_A503); chk("R3 reselect", rd_gctrl, 32'h0000_A503);

      tag = "R5";
      wr(2'd2, 32'h0000_C204); chk("R5 lock set",   rd_chan, 32'h0000_C204);
      wr(2'd2, 32'h0000_0304); chk("R5 ignored",    rd_chan, 32'h0000_C204);
      wr(2'd2, 32'h0000_0105); chk("R5 other chan", rd_chan, 32'h0000_0105);
      wr(2'd2, 32'h0000_0004); chk("R5 reselect",   rd_chan, 32'h0000_C204);

      tag = "R6";
      wr(2'd1, 32'h00BE_EF02); chk("R6 div frozen",  rd_gdiv,  32'h0012_3402);
      wr(2'd0, 32'h0000_9902); chk("R6 ctrl frozen", rd_gctrl, 32'h0000_0002);
      wr(2'd0, 32'h0000_3C03); chk("R6 other gen",   rd_gctrl, 32'h0000_3C03);

      tag = "R4";
      wr(2'd0, 32'h0000_7706); chk("R4 gctrl id6", rd_gctrl, 32'h0000_0000);
      wr(2'd0, 32'h0000_770A); chk("R4 gctrl id10", rd_gctrl, 32'h0000_0000);
      wr(2'd0, 32'h0000_5502); chk("R4 no alias", rd_gctrl, 32'h0000_0002);
      wr(2'd2, 32'h0000_C20A); chk("R4 chan id10", rd_chan, 32'h0000_0000);
      wr(2'd1, 32'h00FF_FF06); chk("R4 gdiv id6", rd_gdiv, 32'h0000_0000);

      tag = "R7";
      wr(2'd2, 32'h0000_8006); chk("R7 lock on gen0", rd_chan, 32'h0000_8006);
      wr(2'd0, 32'h0000_4200); chk("R7 gen0 ctrl",    rd_gctrl, 32'h0000_4200);
      wr(2'd1, 32'h0000_0700); chk("R7 gen0 div",     rd_gdiv,  32'h0000_0700);
      wr(2'd1, 32'h00AA_AA05); chk("R7 gen5 div",     rd_gdiv,  32'h00AA_AA05);

      tag = "R8";
      soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
      chk("R8 gen0 startup ctrl", rd_gctrl, 32'h0000_0500);
      chk("R8 gen0 startup div",  rd_gdiv,  32'h0000_0100);
      chk("R8 chan sel zero",     rd_chan,  32'h0000_0000);
      wr(2'd2, 32'h0000_0004); chk("R8 locked chan kept", rd_chan, 32'h0000_C204);
      wr(2'd1, 32'h0000_0002); chk("R8 locked gen kept",  rd_gdiv, 32'h0012_3402);
      wr(2'd2, 32'h0000_8508); chk("R8 lock gen5",        rd_chan, 32'h0000_8508);
      wr(2'd1, 32'h00FF_FF05); chk("R8 unlocked gen cleared", rd_gdiv, 32'h0000_0005);

      tag = "R10";
      wr_en = 1'b1; wr_reg = 2'd0; wr_data = 32'h0000_6603; soft_rst = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_reg = 2'd3; soft_rst = 1'b0;
      chk("R10 soft wins sel", rd_gctrl, 32'h0000_0500);
      wr(2'd2, 32'h0000_8309); chk("R10 lock gen3", rd_chan, 32'h0000_8309);
      wr(2'd0, 32'h0000_0003); chk("R10 write dropped", rd_gctrl, 32'h0000_0003);

      tag = "R9";
      por_n = 1'b0; repeat (2) @(negedge clk); por_n = 1'b1;
      chk("R9 por gctrl", rd_gctrl, 32'h0000_0500);
      wr(2'd2, 32'h0000_0304); chk("R9 chan unlocked", rd_chan,  32'h0000_0304);
      wr(2'd1, 32'h00BE_EF02); chk("R9 gen2 writable", rd_gdiv,  32'h00BE_EF02);
      wr(2'd0, 32'h0000_7703); chk("R9 gen3 writable", rd_gctrl, 32'h0000_7703);

      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule